// File: doc/BRIEF.md
# Decimating Test Bus Output Selector

This block places one of many internal receiver signals on a shared debug output made of two 16-bit data ports. Selection has two levels. A source code picks one of eight channel blocks or the receive-interface FIFO pair. A tap code then picks which internal point of that channel is shown. Each channel tap is a 32-bit word. Its upper half drives port C and its lower half drives port D. For the receive interface, FIFO word A drives port C and FIFO word B drives port D.

The selected word can pass through at full rate, or it can be decimated by 17. When decimated, the sampling phase is tied to a selectable sync source plus a programmable delay. The block also produces a divided test clock whose period is set in receive-clock cycles, a flag that marks each new sample, and a registered copy of the chosen sync. A single enable turns on the output drivers of both data ports and releases all counters. With the enable clear, the counters are held in reset and every output is quiet.

Top module: `tbus_out_sel`

## Requirements
- R1: Source code 0 to 7 selects that channel, code 8 selects the receive interface (FIFO A onto port C, FIFO B onto port D), and codes 9 to 15 give all-zero data.
- R2: Tap code 0 gives zeros. Tap codes 1 to 9 select channel tap input 0 to 8: time-adjust A, time-adjust B, NCO sine, NCO cosine, CIC, mixer I products, mixer Q products, CFIR, PFIR. Codes 10 to 63 give zeros. Tap word k of channel c sits at bits (c*9+k)*32 of the tap bus, and its bits 31:16 go to port C.
- R3: With decimation off, the output registers take the selected word on every clock, one cycle after it is presented.
- R4: With decimation on, a phase counter steps modulo 17 from 0 after enable. A sample is taken only in the cycle where the phase equals the 4-bit delay. Between samples the outputs hold.
- R5: A pulse on the sync input chosen by the 3-bit sync select forces the phase to 0 in that cycle. The next sample then lands at sync + delay and every 17 cycles after. Pulses on unselected sync inputs have no effect.
- R6: The flag output is high for exactly one cycle, together with each output update. It is therefore high on every cycle when decimation is off.
- R7: The test clock has a period of rate_sel+1 receive cycles and is high for the first ceil((rate_sel+1)/2) of them. A selected sync restarts the divider so that the test clock is high in the cycle after the sync.
- R8: The sync output is the selected sync input delayed by one cycle.
- R9: With the enable clear, output-enable, data, flag, test clock and sync out are all low one cycle later, and the phase and divider counters restart from 0 when the enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tst_en_i | input | 1 | Test bus enable |
| src_sel_i | input | 4 | Source code: channel 0 to 7 or receive interface 8 |
| tap_sel_i | input | 6 | Channel tap code |
| decim_en_i | input | 1 | 1 = decimate by 17, 0 = pass every sample |
| sync_sel_i | input | 3 | Chooses which sync input realigns phase and divider |
| delay_i | input | 4 | Sample phase offset from sync |
| rate_sel_i | input | 5 | Test clock period minus one |
| sync_src_i | input | 8 | Candidate sync pulses |
| ch_taps_i | input | 2304 | Channel taps, 8 channels x 9 taps x 32 bits |
| rx_a_i | input | 16 | Receive FIFO A word |
| rx_b_i | input | 16 | Receive FIFO B word |
| bus_c_o | output | 16 | Data for port C |
| bus_d_o | output | 16 | Data for port D |
| bus_oe_o | output | 1 | Output enable for both data ports |
| tclk_o | output | 1 | Divided test clock |
| flag_o | output | 1 | New-sample flag |
| tsync_o | output | 1 | Registered selected sync |

## Verification
The bench sweeps every source code against tap codes at both ends of the assigned range and beyond it. A mux that is off by one in its tap index, or that leaks data on an unassigned code, then shows the wrong word. In decimating mode it sends sync pulses at arbitrary phases, with delays of 0, 5 and 15, and also pulses the unselected sync lines. A design that counts modulo 16, ignores the delay, or resyncs on the wrong line samples in the wrong cycle. Test-clock rates of 0, 1, 2, 4 and 31 are checked with sync restarts in the middle of a period, which exposes an off-by-one period or a divider that sync does not reset. Toggling the enable in mid-run shows whether any counter keeps its phase across a disable.

// File: rtl/tbus_pkg.sv
package tbus_pkg;
  localparam int unsigned TB_NUM_CH   = 8;
  localparam int unsigned TB_NUM_TAPS = 9;
  localparam int unsigned TB_DW       = 16;
  localparam int unsigned TB_DECIM    = 17;
  localparam int unsigned TB_SYNC_N   = 8;
  localparam int unsigned TB_SRC_W    = 4;
  localparam int unsigned TB_TAP_W    = 6;
  localparam int unsigned TB_DLY_W    = 4;
  localparam int unsigned TB_RATE_W   = 5;
endpackage

// File: rtl/tbus_tap_mux.sv
module tbus_tap_mux #(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned NUM_TAPS = 9,
  parameter int unsigned DW       = 16,
  parameter int unsigned SRC_W    = 4,
  parameter int unsigned TAP_W    = 6,
  parameter int unsigned WW       = 2 * DW
) (
  input  logic [SRC_W-1:0]             src_sel_i,
  input  logic [TAP_W-1:0]             tap_sel_i,
  input  logic [NUM_CH*NUM_TAPS*WW-1:0] ch_taps_i,
  input  logic [DW-1:0]                rx_a_i,
  input  logic [DW-1:0]                rx_b_i,
  output logic [WW-1:0]                word_o
);
  logic [WW-1:0] ch_word [NUM_CH];

  // tap code 0 and codes above NUM_TAPS fall through to zero
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_comb begin
      ch_word[g] = '0;
      for (int t = 0; t < NUM_TAPS; t++) begin
        if (tap_sel_i == TAP_W'(t + 1))
          ch_word[g] = ch_taps_i[(g*NUM_TAPS + t)*WW +: WW];
      end
    end
  end

  always_comb begin
    word_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (src_sel_i == SRC_W'(c)) word_o = ch_word[c];
    end
    if (src_sel_i == SRC_W'(NUM_CH)) word_o = {rx_a_i, rx_b_i};
  end
endmodule

// File: rtl/tbus_decim.sv
module tbus_decim #(
  parameter int unsigned DECIM = 17,
  parameter int unsigned DLY_W = 4,
  parameter int unsigned CNT_W = $clog2(DECIM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             decim_en_i,
  input  logic             sync_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             strobe_o
);
  logic [CNT_W-1:0] cnt_q, eff;

  // sync cycle counts as phase 0
  assign eff      = sync_i ? '0 : cnt_q;
  assign strobe_o = en_i && (!decim_en_i || (eff == CNT_W'(delay_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= (eff == CNT_W'(DECIM - 1)) ? '0 : eff + CNT_W'(1);
  end
endmodule

// File: rtl/tbus_clkgen.sv
module tbus_clkgen #(
  parameter int unsigned RATE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sync_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  output logic              tclk_o
);
  logic [RATE_W-1:0] div_q, eff;
  logic [RATE_W:0]   hi_lim;

  assign eff    = sync_i ? '0 : div_q;
  assign hi_lim = ({1'b0, rate_sel_i} + (RATE_W+1)'(2)) >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      tclk_o <= 1'b0;
    end else if (!en_i) begin
      div_q  <= '0;
      tclk_o <= 1'b0;
    end else begin
      div_q  <= (eff >= rate_sel_i) ? '0 : eff + RATE_W'(1);
      tclk_o <= ({1'b0, eff} < hi_lim);
    end
  end
endmodule

// File: rtl/tbus_out_sel.sv
module tbus_out_sel
  import tbus_pkg::*;
#(
  parameter int unsigned NUM_CH   = TB_NUM_CH,
  parameter int unsigned NUM_TAPS = TB_NUM_TAPS,
  parameter int unsigned DW       = TB_DW,
  parameter int unsigned DECIM    = TB_DECIM,
  parameter int unsigned SYNC_N   = TB_SYNC_N,
  parameter int unsigned SRC_W    = TB_SRC_W,
  parameter int unsigned TAP_W    = TB_TAP_W,
  parameter int unsigned DLY_W    = TB_DLY_W,
  parameter int unsigned RATE_W   = TB_RATE_W,
  parameter int unsigned SSEL_W   = $clog2(SYNC_N),
  parameter int unsigned WW       = 2 * DW
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          tst_en_i,
  input  logic [SRC_W-1:0]              src_sel_i,
  input  logic [TAP_W-1:0]              tap_sel_i,
  input  logic                          decim_en_i,
  input  logic [SSEL_W-1:0]             sync_sel_i,
  input  logic [DLY_W-1:0]              delay_i,
  input  logic [RATE_W-1:0]             rate_sel_i,
  input  logic [SYNC_N-1:0]             sync_src_i,
  input  logic [NUM_CH*NUM_TAPS*WW-1:0] ch_taps_i,
  input  logic [DW-1:0]                 rx_a_i,
  input  logic [DW-1:0]                 rx_b_i,
  output logic [DW-1:0]                 bus_c_o,
  output logic [DW-1:0]                 bus_d_o,
  output logic                          bus_oe_o,
  output logic                          tclk_o,
  output logic                          flag_o,
  output logic                          tsync_o
);
  logic [WW-1:0] sel_word;
  logic          sync_hit, strobe;

  assign sync_hit = tst_en_i && sync_src_i[sync_sel_i];

  tbus_tap_mux #(
    .NUM_CH(NUM_CH), .NUM_TAPS(NUM_TAPS), .DW(DW),
    .SRC_W(SRC_W), .TAP_W(TAP_W), .WW(WW)
  ) mux_i (
    .src_sel_i(src_sel_i), .tap_sel_i(tap_sel_i), .ch_taps_i(ch_taps_i),
    .rx_a_i(rx_a_i), .rx_b_i(rx_b_i), .word_o(sel_word)
  );

  tbus_decim #(.DECIM(DECIM), .DLY_W(DLY_W)) decim_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(tst_en_i), .decim_en_i(decim_en_i),
    .sync_i(sync_hit), .delay_i(delay_i), .strobe_o(strobe)
  );

  tbus_clkgen #(.RATE_W(RATE_W)) clkgen_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(tst_en_i), .sync_i(sync_hit),
    .rate_sel_i(rate_sel_i), .tclk_o(tclk_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_c_o  <= '0;
      bus_d_o  <= '0;
      flag_o   <= 1'b0;
      tsync_o  <= 1'b0;
      bus_oe_o <= 1'b0;
    end else if (!tst_en_i) begin
      bus_c_o  <= '0;
      bus_d_o  <= '0;
      flag_o   <= 1'b0;
      tsync_o  <= 1'b0;
      bus_oe_o <= 1'b0;
    end else begin
      if (strobe) {bus_c_o, bus_d_o} <= sel_word;
      flag_o   <= strobe;
      tsync_o  <= sync_hit;
      bus_oe_o <= 1'b1;
    end
  end
endmodule

// File: rtl/tbus_out_sel_chk.sv
module tbus_out_sel_chk #(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned NUM_TAPS = 9,
  parameter int unsigned DW       = 16,
  parameter int unsigned SYNC_N   = 8,
  parameter int unsigned SRC_W    = 4,
  parameter int unsigned TAP_W    = 6,
  parameter int unsigned SSEL_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tst_en_i,
  input logic [SRC_W-1:0]  src_sel_i,
  input logic [TAP_W-1:0]  tap_sel_i,
  input logic              decim_en_i,
  input logic [SSEL_W-1:0] sync_sel_i,
  input logic [SYNC_N-1:0] sync_src_i,
  input logic [DW-1:0]     bus_c_o,
  input logic [DW-1:0]     bus_d_o,
  input logic              bus_oe_o,
  input logic              tclk_o,
  input logic              flag_o,
  input logic              tsync_o
);
  p_unused_src_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tst_en_i && !decim_en_i && src_sel_i > SRC_W'(NUM_CH))
      |=> (bus_c_o == '0 && bus_d_o == '0));

  p_unused_tap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tst_en_i && !decim_en_i && src_sel_i < SRC_W'(NUM_CH) &&
     (tap_sel_i == '0 || tap_sel_i > TAP_W'(NUM_TAPS)))
      |=> (bus_c_o == '0 && bus_d_o == '0));

  p_flag_full_rate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tst_en_i && !decim_en_i) |=> flag_o);

  p_hold_between_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_o && $past(bus_oe_o) && !flag_o) |-> ($stable(bus_c_o) && $stable(bus_d_o)));

  p_sync_tclk_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tst_en_i && sync_src_i[sync_sel_i]) |=> tclk_o);

  p_tsync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tst_en_i && sync_src_i[sync_sel_i]) |=> tsync_o);

  p_off_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tst_en_i |=> (!bus_oe_o && !tclk_o && !flag_o && !tsync_o &&
                   bus_c_o == '0 && bus_d_o == '0));
endmodule

bind tbus_out_sel tbus_out_sel_chk #(
  .NUM_CH(NUM_CH), .NUM_TAPS(NUM_TAPS), .DW(DW), .SYNC_N(SYNC_N),
  .SRC_W(SRC_W), .TAP_W(TAP_W), .SSEL_W(SSEL_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .tst_en_i(tst_en_i), .src_sel_i(src_sel_i),
  .tap_sel_i(tap_sel_i), .decim_en_i(decim_en_i), .sync_sel_i(sync_sel_i),
  .sync_src_i(sync_src_i), .bus_c_o(bus_c_o), .bus_d_o(bus_d_o),
  .bus_oe_o(bus_oe_o), .tclk_o(tclk_o), .flag_o(flag_o), .tsync_o(tsync_o)
);

// File: tb/tbus_out_sel_tb.sv
`timescale 1ns/1ps
module tbus_out_sel_tb_top;
  localparam int NCH = 8, NTAP = 9, WW = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tst_en = 1'b0, decim_en = 1'b0;
  logic [3:0] src_sel = '0, delay = '0;
  logic [5:0] tap_sel = '0;
  logic [2:0] sync_sel = '0;
  logic [4:0] rate_sel = '0;
  logic [7:0] sync_src = '0;
  logic [NCH*NTAP*WW-1:0] ch_taps = '0;
  logic [15:0] rx_a = '0, rx_b = '0;
  logic [15:0] bus_c, bus_d;
  logic bus_oe, tclk, flag, tsync;

  int checks = 0, errors = 0;
  bit run = 1'b0;
  string cur_req = "R9";
  int cyc = 0;

  always #2.5 clk = ~clk;

  tbus_out_sel dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tst_en_i(tst_en), .src_sel_i(src_sel),
    .tap_sel_i(tap_sel), .decim_en_i(decim_en), .sync_sel_i(sync_sel),
    .delay_i(delay), .rate_sel_i(rate_sel), .sync_src_i(sync_src),
    .ch_taps_i(ch_taps), .rx_a_i(rx_a), .rx_b_i(rx_b), .bus_c_o(bus_c),
    .bus_d_o(bus_d), .bus_oe_o(bus_oe), .tclk_o(tclk), .flag_o(flag),
    .tsync_o(tsync)
  );

  // tap stimulus changes every cycle, just after the edge
  always @(posedge clk) begin
    #1;
    cyc++;
    for (int c = 0; c < NCH; c++)
      for (int t = 0; t < NTAP; t++)
        ch_taps[(c*NTAP+t)*WW +: WW] = {4'(c), 4'(t), 8'(cyc), 16'(cyc*3 + c*7 + t)};
    rx_a = 16'(cyc * 5);
    rx_b = ~16'(cyc);
  end

  // behavioural reference
  int m_cnt = 0, m_div = 0;
  logic [15:0] m_c = '0, m_d = '0;
  bit m_flag = 0, m_tclk = 0, m_tsync = 0, m_oe = 0;

  function automatic logic [31:0] pick();
    if (src_sel < 8) begin
      if (tap_sel >= 1 && tap_sel <= 9)
        return ch_taps[(int'(src_sel)*NTAP + int'(tap_sel) - 1)*WW +: WW];
      return 32'h0;
    end
    if (src_sel == 8) return {rx_a, rx_b};
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni || !tst_en) begin
      m_cnt = 0; m_div = 0; m_c = '0; m_d = '0;
      m_flag = 0; m_tclk = 0; m_tsync = 0; m_oe = 0;
    end else begin
      bit hit, strobe;
      int eff, deff;
      hit    = sync_src[sync_sel];
      eff    = hit ? 0 : m_cnt;
      strobe = !decim_en || (eff == int'(delay));
      if (strobe) {m_c, m_d} = pick();
      m_flag = strobe;
      m_cnt  = (eff == 16) ? 0 : eff + 1;
      deff   = hit ? 0 : m_div;
      m_tclk = deff < (int'(rate_sel) + 2) / 2;
      m_div  = (deff >= int'(rate_sel)) ? 0 : deff + 1;
      m_tsync = hit;
      m_oe   = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      chk({bus_c, bus_d} == {m_c, m_d}, cur_req, "data", {bus_c, bus_d}, {m_c, m_d});
      chk(flag == m_flag, "R6", "flag", 32'(flag), 32'(m_flag));
      chk(tclk == m_tclk, "R7", "tclk", 32'(tclk), 32'(m_tclk));
      chk(tsync == m_tsync, "R8", "tsync", 32'(tsync), 32'(m_tsync));
      chk(bus_oe == m_oe, "R9", "oe", 32'(bus_oe), 32'(m_oe));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input int bit_i);
    sync_src = 8'(1 << bit_i);
    step(1);
    sync_src = '0;
  endtask

  initial begin
    // reset state, R9
    run = 1'b1;
    step(3);
    rst_ni = 1'b1;
    src_sel = 4'd2; tap_sel = 6'd3;
    pulse(0);
    step(4);

    // R1 R2 R3: sweep sources and taps at full rate
    cur_req = "R1 R2 R3";
    tst_en = 1'b1;
    for (int s = 0; s < 16; s++) begin
      foreach (tap_list[k]) begin
        src_sel = 4'(s); tap_sel = tap_list[k];
        step(2);
      end
    end

    // R4 R5: decimate by 17, sync realigns phase
    cur_req = "R4 R5";
    decim_en = 1'b1; src_sel = 4'd3; tap_sel = 6'd4;
    sync_sel = 3'd2; delay = 4'd5;
    step(60);
    pulse(2);
    step(23);
    pulse(6);            // unselected line
    step(11);
    pulse(2);
    step(9);
    delay = 4'd0; pulse(2);
    step(40);
    delay = 4'd15; sync_sel = 3'd7; pulse(7);
    step(30);
    pulse(2);            // no longer selected
    step(40);

    // R7 R8: test clock rates with mid-period syncs
    cur_req = "R7 R8";
    decim_en = 1'b0; sync_sel = 3'd5;
    foreach (rates[k]) begin
      rate_sel = rates[k];
      step(37);
      pulse(5);
      step(45);
      pulse(1);
      step(9);
    end

    // R9: disable mid-run, counters restart from zero
    cur_req = "R9";
    decim_en = 1'b1; delay = 4'd7; rate_sel = 5'd6;
    step(20);
    tst_en = 1'b0;
    pulse(5);
    step(10);
    tst_en = 1'b1;
    step(45);

    run = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [5:0] tap_list [6] = '{6'd0, 6'd1, 6'd5, 6'd9, 6'd10, 6'd63};
  logic [4:0] rates [5] = '{5'd0, 5'd1, 5'd2, 5'd4, 5'd31};

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule